// File: doc/BRIEF.md
# Sensor Row Readout Sequencer

This block is the host-side sequencer that walks a column-parallel-ADC image sensor through a frame, one row at a time. For each row it presents a row select, pulses an active-low conversion request and waits for the sensor's active-low conversion-complete reply. It then pulses an active-low transfer strobe, which moves the converted row into the sensor's output register. Finally it holds an active-low read enable low for a programmed number of clocks while the row is shifted out. A frame covers a window of rows from `first_row` to `last_row`, so a partial window can be scanned at a higher frame rate.

There are two ways of running. In pipelined mode the conversion of the next row starts two cycles after the read enable falls, so conversion overlaps the readout of the previous row and the first row of a frame has no readout ahead of it. In burst mode a new conversion waits until the readout has finished. After the last row of the window, one more transfer-and-read with no conversion drains the pipeline, and then a one-cycle frame-end marker is raised. A conversion that is not answered within a programmed number of clocks raises an error flag and returns the sequencer to idle.

States: `S_IDLE` (waiting for `start`), `S_STROBE` (conversion request), `S_CONVERT` (waiting for completion, timing out), `S_DRAIN` (completion seen, readout still busy), `S_LOAD` (transfer strobe), `S_LEAD_A`/`S_LEAD_B` (pipelined two-cycle spacing after the read enable falls), `S_BWAIT` (burst wait for the readout to end), `S_FLUSH` (last readout running), `S_END` (frame-end marker). Transitions: IDLE→STROBE on an accepted start; STROBE→CONVERT; CONVERT→LOAD on completion with the readout idle, CONVERT→DRAIN on completion with the readout busy, CONVERT→IDLE on timeout; DRAIN→LOAD when the readout ends; LOAD→FLUSH after the last row, LOAD→BWAIT in burst mode, LOAD→LEAD_A in pipelined mode; LEAD_A→LEAD_B→STROBE; BWAIT→STROBE when the readout ends; FLUSH→END when the readout ends; END→IDLE.

Top module: `row_readout_ctrl`

## Requirements
- R1: While reset is held and on leaving it, `conv_go_n`, `xfer_n` and `rd_en_n` are high (all three strobes are active low), and `frame_start`, `frame_end`, `row_valid` and `timeout_err` are low.
- R2: Each row of the window gets exactly one `conv_go_n` low pulse of one cycle, with `sel_row` stepping upward by one from `first_row` to `last_row`; `frame_start` is high exactly once per frame, in the cycle of the first request.
- R3: `sel_row` keeps its value from the request cycle until the cycle in which `conv_done_n` is sampled low.
- R4: Each row gets exactly one `xfer_n` low pulse of one cycle, and `xfer_n` is never low while `rd_en_n` is low.
- R5: Starting the cycle after each transfer pulse, `rd_en_n` is low for exactly `read_len` (at least 1) cycles; `row_valid` is high exactly while `rd_en_n` is low, and `valid_row` then names the row that was transferred.
- R6: In pipelined mode (`burst_mode` = 0) every request after the first of a frame comes exactly two cycles after the cycle in which `rd_en_n` fell.
- R7: If `conv_done_n` is sampled low at the end of cycle c and the previous readout's last low cycle is e, the transfer pulse comes in cycle max(c+1, e+2).
- R8: In burst mode (`burst_mode` = 1) no request is issued while `rd_en_n` is low, and the next request comes in the cycle after `rd_en_n` returns high.
- R9: The first row of a frame has no readout ahead of it: `rd_en_n` stays high from the accepted start until the cycle after the first transfer.
- R10: After the last row's transfer, no further request is issued; `frame_end` is high for one cycle, in the cycle after the final readout ends, and the sequencer is then idle.
- R11: With a limit of T clocks (T ≥ 1) and a request in cycle s, a completion sampled by the end of cycle s+T is accepted; otherwise `timeout_err` rises in cycle s+T+1, no transfer follows, and the sequencer is idle. The flag clears when the next frame is accepted.
- R12: `start` has no effect while a frame is in progress.
- R13: Mode, window and read length are captured when a frame is accepted; changes to them during the frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (accepted only when idle) |
| burst_mode | input | 1 | 1 = burst, 0 = pipelined |
| first_row | input | ROW_W | First row of the window |
| last_row | input | ROW_W | Last row of the window (not below `first_row`) |
| read_len | input | LEN_W | Read enable length in clocks, at least 1 |
| done_timeout | input | TMO_W | Completion limit in clocks, at least 1 |
| conv_done_n | input | 1 | Sensor conversion complete, active low |
| sel_row | output | ROW_W | Row select to the sensor |
| conv_go_n | output | 1 | Conversion request, active low |
| xfer_n | output | 1 | Transfer to output register, active low |
| rd_en_n | output | 1 | Data read enable, active low |
| row_valid | output | 1 | Row data is being read out |
| valid_row | output | ROW_W | Row being read out |
| frame_start | output | 1 | First request of a frame |
| frame_end | output | 1 | Frame finished, one cycle |
| timeout_err | output | 1 | Completion timed out |

## Verification
The properties assume a sensor that answers each request with a single low cycle on `conv_done_n`, only after that request, and that `read_len`, `done_timeout` and the window order stay within their stated ranges. The stimulus uses a reactive sensor model that raises completion a fixed delay after each observed request, or never in the timeout cases. It keeps `read_len` and the limit at 1 or above and always programs `first_row` ≤ `last_row`. The only out-of-turn inputs it applies are mid-frame `start` pulses and configuration changes, which the design must ignore.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    // Sequencer states; the encoding carries no meaning outside the block.
    typedef enum logic [3:0] {
        S_IDLE,
        S_STROBE,
        S_CONVERT,
        S_DRAIN,
        S_LOAD,
        S_LEAD_A,
        S_LEAD_B,
        S_BWAIT,
        S_FLUSH,
        S_END
    } rdo_state_e;

endpackage

// File: rtl/rdo_read_timer.sv
// Holds the readout busy for exactly len cycles after a kick.
module rdo_read_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic [LEN_W-1:0] len,
    output logic             busy
);
    logic [LEN_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain_q <= '0;
        end else if (kick) begin
            busy     <= 1'b1;
            remain_q <= len - LEN_W'(1);
        end else if (busy) begin
            if (remain_q == '0) begin
                busy <= 1'b0;
            end else begin
                remain_q <= remain_q - LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/rdo_done_watch.sv
// Counts cycles spent waiting for conversion completion.
module rdo_done_watch #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);
    logic [TMO_W-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (run) begin
            wait_q <= wait_q + TMO_W'(1);
        end else begin
            wait_q <= '0;
        end
    end

    assign expire = run && (wait_q == limit - TMO_W'(1));
endmodule

// File: rtl/rdo_row_track.sv
// Tracks the row under conversion and the row in the output register.
module rdo_row_track #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [ROW_W-1:0] first,
    input  logic [ROW_W-1:0] last,
    input  logic             advance,
    output logic [ROW_W-1:0] conv_row,
    output logic [ROW_W-1:0] read_row,
    output logic             at_last
);
    assign at_last = (conv_row == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_row <= '0;
            read_row <= '0;
        end else if (init) begin
            conv_row <= first;
        end else if (advance) begin
            read_row <= conv_row;
            if (!at_last) begin
                conv_row <= conv_row + ROW_W'(1);
            end
        end
    end
endmodule

// File: rtl/row_readout_ctrl.sv
module row_readout_ctrl
    import rdo_pkg::*;
#(
    parameter int ROW_W = 10,
    parameter int LEN_W = 16,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             burst_mode,
    input  logic [ROW_W-1:0] first_row,
    input  logic [ROW_W-1:0] last_row,
    input  logic [LEN_W-1:0] read_len,
    input  logic [TMO_W-1:0] done_timeout,
    input  logic             conv_done_n,
    output logic [ROW_W-1:0] sel_row,
    output logic             conv_go_n,
    output logic             xfer_n,
    output logic             rd_en_n,
    output logic             row_valid,
    output logic [ROW_W-1:0] valid_row,
    output logic             frame_start,
    output logic             frame_end,
    output logic             timeout_err
);
    rdo_state_e state, nxt;

    // Frame configuration captured at acceptance
    logic             cfg_burst_q;
    logic [ROW_W-1:0] cfg_last_q;
    logic [LEN_W-1:0] cfg_len_q;
    logic [TMO_W-1:0] cfg_tmo_q;
    logic             first_pend_q;
    logic             err_q;

    logic             rd_busy;
    logic             tmo_hit;
    logic             at_last;
    logic [ROW_W-1:0] conv_row;
    logic [ROW_W-1:0] read_row;
    logic             accept;
    logic             done_seen;

    assign accept    = (state == S_IDLE) && start && !rd_busy;
    assign done_seen = (state == S_CONVERT) && !conv_done_n;

    rdo_read_timer #(.LEN_W(LEN_W)) u_read (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (state == S_LOAD),
        .len   (cfg_len_q),
        .busy  (rd_busy)
    );

    rdo_done_watch #(.TMO_W(TMO_W)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == S_CONVERT),
        .limit  (cfg_tmo_q),
        .expire (tmo_hit)
    );

    rdo_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (accept),
        .first    (first_row),
        .last     (cfg_last_q),
        .advance  (state == S_LOAD),
        .conv_row (conv_row),
        .read_row (read_row),
        .at_last  (at_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Frame configuration, first-row marker and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_burst_q  <= 1'b0;
            cfg_last_q   <= '0;
            cfg_len_q    <= LEN_W'(1);
            cfg_tmo_q    <= TMO_W'(1);
            first_pend_q <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            if (accept) begin
                cfg_burst_q  <= burst_mode;
                cfg_last_q   <= last_row;
                cfg_len_q    <= read_len;
                cfg_tmo_q    <= done_timeout;
                first_pend_q <= 1'b1;
                err_q        <= 1'b0;
            end else if (state == S_STROBE) begin
                first_pend_q <= 1'b0;
            end
            if ((state == S_CONVERT) && conv_done_n && tmo_hit) begin
                err_q <= 1'b1;
            end
        end
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept) nxt = S_STROBE;
            end
            S_STROBE: begin
                nxt = S_CONVERT;
            end
            S_CONVERT: begin
                if (done_seen) begin
                    nxt = rd_busy ? S_DRAIN : S_LOAD;
                end else if (tmo_hit) begin
                    nxt = S_IDLE;
                end
            end
            S_DRAIN: begin
                if (!rd_busy) nxt = S_LOAD;
            end
            S_LOAD: begin
                if (at_last)          nxt = S_FLUSH;
                else if (cfg_burst_q) nxt = S_BWAIT;
                else                  nxt = S_LEAD_A;
            end
            S_LEAD_A: begin
                nxt = S_LEAD_B;
            end
            S_LEAD_B: begin
                nxt = S_STROBE;
            end
            S_BWAIT: begin
                if (!rd_busy) nxt = S_STROBE;
            end
            S_FLUSH: begin
                if (!rd_busy) nxt = S_END;
            end
            S_END: begin
                nxt = S_IDLE;
            end
            default: begin
                nxt = S_IDLE;
            end
        endcase
    end

    // Output decode
    always_comb begin
        sel_row     = conv_row;
        conv_go_n   = !(state == S_STROBE);
        xfer_n      = !(state == S_LOAD);
        rd_en_n     = !rd_busy;
        row_valid   = rd_busy;
        valid_row   = read_row;
        frame_start = (state == S_STROBE) && first_pend_q;
        frame_end   = (state == S_END);
        timeout_err = err_q;
    end
endmodule

// File: rtl/rdo_checker.sv
module rdo_checker
    import rdo_pkg::*;
#(
    parameter int ROW_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input rdo_state_e       state,
    input logic             cfg_burst,
    input logic [ROW_W-1:0] sel_row,
    input logic             conv_go_n,
    input logic             xfer_n,
    input logic             rd_en_n,
    input logic             conv_done_n,
    input logic             frame_start,
    input logic             frame_end,
    input logic             timeout_err
);
    // R2
    go_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_go_n |=> conv_go_n);

    // R2
    frame_start_on_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !conv_go_n);

    // R3
    row_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CONVERT) |-> $stable(sel_row));

    // R4
    xfer_not_during_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_n |-> rd_en_n);

    // R5
    read_follows_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_n |=> !rd_en_n);

    // R6
    pipe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_go_n && !cfg_burst && !frame_start) |-> ($past(!rd_en_n, 2) && $past(rd_en_n, 3)));

    // R8
    burst_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_burst && !rd_en_n) |-> conv_go_n);

    // R10
    frame_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (!frame_end && conv_go_n));

    // R11
    timeout_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> $past(state == S_CONVERT && conv_done_n));

    // R4
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!conv_go_n, !xfer_n, frame_end}));
endmodule

bind row_readout_ctrl rdo_checker #(.ROW_W(ROW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .cfg_burst   (cfg_burst_q),
    .sel_row     (sel_row),
    .conv_go_n   (conv_go_n),
    .xfer_n      (xfer_n),
    .rd_en_n     (rd_en_n),
    .conv_done_n (conv_done_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .timeout_err (timeout_err)
);

// File: tb/sim_row_readout_ctrl.sv
module sim_row_readout_ctrl;
    localparam int ROW_W = 10;
    localparam int LEN_W = 16;
    localparam int TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             burst_mode = 1'b0;
    logic [ROW_W-1:0] first_row = '0;
    logic [ROW_W-1:0] last_row = '0;
    logic [LEN_W-1:0] read_len = LEN_W'(1);
    logic [TMO_W-1:0] done_timeout = TMO_W'(100);
    logic             conv_done_n = 1'b1;
    logic [ROW_W-1:0] sel_row;
    logic             conv_go_n, xfer_n, rd_en_n, row_valid;
    logic [ROW_W-1:0] valid_row;
    logic             frame_start, frame_end, timeout_err;

    always #2 clk = ~clk;

    row_readout_ctrl #(.ROW_W(ROW_W), .LEN_W(LEN_W), .TMO_W(TMO_W)) u0 (
        .clk, .rst_n, .start, .burst_mode, .first_row, .last_row, .read_len,
        .done_timeout, .conv_done_n, .sel_row, .conv_go_n, .xfer_n, .rd_en_n,
        .row_valid, .valid_row, .frame_start, .frame_end, .timeout_err
    );

    int n_chk = 0;
    int n_fail = 0;

    // Monitor state
    int cyc = 0;
    int ns, nl, nf, nr, nfs, nfe, addr_bad, vr_bad, fs_bad, ov_bad;
    int s_cyc[16], s_row[16], l_cyc[16], f_cyc[16], r_cyc[16];
    int fe_cyc, err_cyc, hold_row, exp_first;
    logic prev_rd = 1'b1;
    logic prev_err = 1'b0;
    logic holding = 1'b0;

    // Sensor model state
    int sens_d = 1;
    int sens_cnt = 0;
    bit sens_on = 1'b1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        ns = 0; nl = 0; nf = 0; nr = 0; nfs = 0; nfe = 0;
        addr_bad = 0; vr_bad = 0; fs_bad = 0; ov_bad = 0;
        fe_cyc = -1; err_cyc = -1; holding = 1'b0;
    endtask

    // Sensor: answers each request with one low cycle, sens_d cycles later
    initial forever begin
        @(negedge clk);
        conv_done_n = 1'b1;
        if (sens_cnt != 0) begin
            sens_cnt--;
            if (sens_cnt == 0 && sens_on) conv_done_n = 1'b0;
        end
        if (!conv_go_n) sens_cnt = sens_d;
    end

    // Port monitor, sampled mid-cycle
    initial forever begin
        @(posedge clk);
        #1;
        cyc++;
        if (!conv_go_n) begin
            if (ns < 16) begin
                s_cyc[ns] = cyc;
                s_row[ns] = int'(sel_row);
            end
            ns++;
            holding = 1'b1;
            hold_row = int'(sel_row);
        end else if (holding && int'(sel_row) != hold_row) begin
            addr_bad++;
        end
        if (holding && !conv_done_n) holding = 1'b0;
        if (frame_start) begin
            nfs++;
            if (conv_go_n) fs_bad++;
        end
        if (!xfer_n) begin
            if (nl < 16) l_cyc[nl] = cyc;
            nl++;
            if (!rd_en_n) ov_bad++;
        end
        if (!rd_en_n && prev_rd) begin
            if (nf < 16) f_cyc[nf] = cyc;
            nf++;
        end
        if (rd_en_n && !prev_rd) begin
            if (nr < 16) r_cyc[nr] = cyc;
            nr++;
        end
        if (!rd_en_n) begin
            if (!row_valid || int'(valid_row) != exp_first + nf - 1) vr_bad++;
        end else if (row_valid) begin
            vr_bad++;
        end
        prev_rd = rd_en_n;
        if (frame_end) begin
            fe_cyc = cyc;
            nfe++;
        end
        if (timeout_err && !prev_err) err_cyc = cyc;
        prev_err = timeout_err;
    end

    task automatic run_frame(input bit b, input int first, input int n, input int len,
                             input int d, input bit chg);
        int se[16];
        int le[16];
        int guard;
        int bad_row, bad_s, bad_l, bad_rd;
        @(negedge clk);
        clear_mon();
        exp_first = first;
        sens_d = d;
        sens_on = 1'b1;
        burst_mode = b;
        first_row = first[ROW_W-1:0];
        last_row = ROW_W'(first + n - 1);
        read_len = len[LEN_W-1:0];
        done_timeout = TMO_W'(1000);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (chg) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            first_row = ROW_W'(5);
            last_row = ROW_W'(900);
            read_len = LEN_W'(2);
            burst_mode = !b;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (nfe == 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(nfe != 0, "R10", "frame end reached", nfe, 1);
        repeat (2) @(negedge clk);

        se[0] = s_cyc[0];
        le[0] = se[0] + d + 1;
        for (int k = 1; k < n; k++) begin
            if (b) begin
                se[k] = le[k-1] + len + 2;
                le[k] = se[k] + d + 1;
            end else begin
                se[k] = le[k-1] + 3;
                le[k] = se[k] + (((d + 1) > (len - 1)) ? (d + 1) : (len - 1));
            end
        end
        bad_row = 0; bad_s = 0; bad_l = 0; bad_rd = 0;
        for (int k = 0; k < n; k++) begin
            if (s_row[k] != first + k) bad_row++;
            if (s_cyc[k] != se[k]) bad_s++;
            if (l_cyc[k] != le[k]) bad_l++;
            if (f_cyc[k] != le[k] + 1 || r_cyc[k] != le[k] + len + 1) bad_rd++;
        end
        chk(ns == n && nfs == 1 && fs_bad == 0, "R2", "request count", ns, n);
        chk(bad_row == 0, "R2", "row order mismatches", bad_row, 0);
        chk(addr_bad == 0, "R3", "row select changes", addr_bad, 0);
        chk(nl == n && ov_bad == 0, "R4", "transfer count", nl, n);
        chk(bad_l == 0, "R7", "transfer timing mismatches", bad_l, 0);
        chk(nf == n && nr == n && bad_rd == 0, "R5", "read windows wrong", bad_rd, 0);
        chk(vr_bad == 0, "R5", "row_valid/valid_row mismatches", vr_bad, 0);
        chk(bad_s == 0, b ? "R8" : "R6", "request timing mismatches", bad_s, 0);
        chk(f_cyc[0] == le[0] + 1, "R9", "first read start cycle", f_cyc[0], le[0] + 1);
        chk(nfe == 1 && fe_cyc == le[n-1] + len + 2, "R10", "frame end cycle", fe_cyc, le[n-1] + len + 2);
        if (chg) begin
            chk(nfs == 1 && ns == n, "R12", "requests after mid-frame start", ns, n);
            chk(s_row[n-1] == first + n - 1 && r_cyc[n-1] - f_cyc[n-1] == len,
                "R13", "last window row", s_row[n-1], first + n - 1);
        end
    endtask

    task automatic run_tmo(input int t, input int d, input bit on);
        @(negedge clk);
        clear_mon();
        exp_first = 7;
        sens_d = d;
        sens_on = on;
        burst_mode = 1'b0;
        first_row = ROW_W'(7);
        last_row = ROW_W'(7);
        read_len = LEN_W'(2);
        done_timeout = t[TMO_W-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (t + 14) @(negedge clk);
        if (on && d <= t) begin
            chk(err_cyc == -1 && nfe == 1 && nl == 1, "R11", "completion at limit accepted", err_cyc, -1);
        end else begin
            chk(err_cyc == s_cyc[0] + t + 1, "R11", "timeout flag cycle", err_cyc, s_cyc[0] + t + 1);
            chk(nl == 0 && nfe == 0 && ns == 1, "R11", "transfers after timeout", nl, 0);
            chk(timeout_err == 1'b1, "R11", "flag held", int'(timeout_err), 1);
        end
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_mon();
        exp_first = 0;
        repeat (3) @(negedge clk);
        chk(conv_go_n && xfer_n && rd_en_n, "R1", "strobes in reset", int'({conv_go_n, xfer_n, rd_en_n}), 7);
        chk(!frame_start && !frame_end && !row_valid && !timeout_err, "R1", "markers in reset",
            int'({frame_start, frame_end, row_valid, timeout_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(conv_go_n && xfer_n && rd_en_n && !frame_end && !row_valid, "R1", "idle after reset",
            int'({conv_go_n, xfer_n, rd_en_n}), 7);

        for (int b = 0; b < 2; b++) begin
            for (int n = 1; n <= 3; n++) begin
                for (int len = 1; len <= 6; len++) begin
                    for (int d = 1; d <= 4; d++) begin
                        run_frame(b[0], (len % 2 == 1) ? (1024 - n) : (d - 1) * 100, n, len, d,
                                  (len == 6 && d == 4));
                    end
                end
            end
        end

        run_tmo(3, 3, 1'b1);
        run_tmo(3, 4, 1'b1);
        run_tmo(1, 1, 1'b0);
        run_frame(1'b0, 0, 2, 3, 2, 1'b0);
        chk(timeout_err == 1'b0, "R11", "flag cleared by next frame", int'(timeout_err), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule